// File: doc/BRIEF.md
# Selectable-Rate Match Timer Bank

This block holds eight match-timer channels, numbered 4 through 11, behind one register bus. Every channel has a 32-bit counter, a 32-bit match value and a control word. The control word sets which of five tick strobes advances the counter, whether the counter is cleared when a match fires, and whether the match repeats or fires once. An odd channel can also compare against its even neighbour's counter instead of its own. The tick strobes come from outside the block and are one clock cycle wide. A counter advances by one on every clock cycle in which its chosen strobe is high.

A match fires on the cycle in which the compared counter steps onto the match value. The match sets that channel's status bit when the channel is enabled. One interrupt line stays high while any channel's status bit is set. On the upper four channels, a read of the odd channel's counter can also copy the even partner's count into a shared snapshot register. Software then reads that copy at its own pace, and the copy matches the read it was taken with.

Bus accesses take one cycle. Writes take effect at the clock edge. Read data comes back registered one cycle after the read, with a valid strobe. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `ctmr_bank`

## Requirements
- R1: Byte addresses: channel k (k = 4..11) has its counter at 0x40+4(k-4), its match value at 0x80+4(k-4) and its control word at 0xC0+4(k-4). The status register is at 0x14 and the enable register at 0x1C, both using bit k for channel k. The snapshot is at 0x20. A written match value reads back unchanged one cycle after the read.
- R2: Control bits [2:0] pick the counter's tick strobe: 1 picks tick[0] (32.768 kHz), 2 picks tick[1] (1 kHz), 3 picks tick[2] (1 Hz), 4 picks tick[3] (1 MHz) and 5 picks tick[4] (external). Codes 0, 6 and 7 stop the counter. A counter gains exactly one per cycle in which its chosen strobe is high.
- R3: A bus write to a counter sets it to the written value, and the increment of that cycle is dropped.
- R4: When control bit 3 is set, a match clears the channel's own counter to 0 in the same edge.
- R5: When control bit 6 is set, a match fires every time the compared counter steps onto the match value. When it is clear, the channel fires once after its counter or match register is written, and then stays silent.
- R6: When control bit 7 is clear, channels 5, 7, 9 and 11 compare against the counter of channel 4, 6, 8 or 10, and their own counters hold their value. When it is set, they compare against and advance their own counters.
- R7: Channels 8-11 keep 10 control bits. On these channels, control bit 8 set stops the counter whatever the code in bits [2:0].
- R8: Channels 4-7 keep 8 control bits. Bits [9:8] of a write to them are dropped and read back as 0.
- R9: A read of channel 9's or channel 11's counter, while its control bit 9 is set, copies channel 8's or channel 10's current count into the snapshot register. The copy is visible from the next cycle. Reads without bit 9 set leave the snapshot unchanged.
- R10: A match sets status bit k only when enable bit k is set. Writing 1 to a status bit clears it. The interrupt output is high exactly while any status bit 4-11 is set.
- R11: If a channel's match and a write-one-to-clear of its status bit fall in the same cycle, the status bit ends up set.
- R12: After reset all counters, match values, control words, enables, status bits and the snapshot are 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High the cycle after a read |
| tick | input | 5 | Tick strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq | output | 1 | Shared interrupt, level |

## Verification
Two functions can land on the same edge: a channel's match setting its status bit, and a bus write clearing that same bit. The bench runs a periodic channel up to one step below its match value. It then issues the status-clear write in the very cycle it raises the selected tick strobe. It judges the outcome by reading the status register afterwards and expecting the bit still set. The same approach is used to collide a counter write with a tick, where the written value must win over the increment.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned AW      = 8;
  localparam int unsigned NTICK   = 5;
  localparam int unsigned FIRST   = 4;

  localparam logic [AW-1:0] A_STAT  = 8'h14;
  localparam logic [AW-1:0] A_IEN   = 8'h1C;
  localparam logic [AW-1:0] A_SNAP  = 8'h20;
  localparam logic [AW-1:0] A_CNT   = 8'h40;
  localparam logic [AW-1:0] A_MAT   = 8'h80;
  localparam logic [AW-1:0] A_CTL   = 8'hC0;

  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_32K  = 3'd1,
    SRC_1K   = 3'd2,
    SRC_1HZ  = 3'd3,
    SRC_1M   = 3'd4,
    SRC_EXT  = 3'd5
  } src_e;

  localparam int unsigned B_CLR   = 3;
  localparam int unsigned B_PER   = 6;
  localparam int unsigned B_OWN   = 7;
  localparam int unsigned B_HALT  = 8;
  localparam int unsigned B_SNAP  = 9;
endpackage

// File: rtl/ctmr_chan.sv
module ctmr_chan
  import ctmr_pkg::*;
#(
  parameter int unsigned CW     = 32,
  parameter int unsigned CTLW   = 10,
  parameter bit          IS_EXT = 1'b0,
  parameter bit          IS_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic             mat_we,
  input  logic             ctl_we,
  input  logic [CW-1:0]    wdata,
  input  logic [NTICK-1:0] tick_in,
  input  logic [CW-1:0]    part_cnt,
  input  logic             part_inc,
  output logic [CW-1:0]    cnt_q,
  output logic             inc_o,
  output logic             hit_o,
  output logic [CW-1:0]    mat_q,
  output logic [CTLW-1:0]  ctl_q
);
  localparam logic [CTLW-1:0] KEEP = IS_EXT ? {CTLW{1'b1}}
                                            : {{(CTLW-8){1'b0}}, 8'hFF};

  logic [CW-1:0]   cnt_d;
  logic [CW-1:0]   mat_d;
  logic [CTLW-1:0] ctl_d;
  logic            armed_q, armed_d;
  logic            sel_tick;
  logic            run_own;
  logic            use_own;
  logic [CW-1:0]   src_cnt;
  logic            src_inc;
  logic            cnt_en, armed_en;

  // strobe selection by code
  always_comb begin
    sel_tick = 1'b0;
    case (src_e'(ctl_q[2:0]))
      SRC_32K: sel_tick = tick_in[0];
      SRC_1K:  sel_tick = tick_in[1];
      SRC_1HZ: sel_tick = tick_in[2];
      SRC_1M:  sel_tick = tick_in[3];
      SRC_EXT: sel_tick = tick_in[4];
      default: sel_tick = 1'b0;
    endcase
  end

  always_comb begin
    use_own = ctl_q[B_OWN] | !IS_ODD;
    run_own = use_own & !(IS_EXT & ctl_q[B_HALT]);
    inc_o   = run_own & sel_tick & !cnt_we;
    src_cnt = use_own ? cnt_q : part_cnt;
    src_inc = use_own ? inc_o : part_inc;
    hit_o   = src_inc && ((src_cnt + 1'b1) == mat_q) && (ctl_q[B_PER] || armed_q);
  end

  // next state
  always_comb begin
    if (cnt_we)                   cnt_d = wdata;
    else if (hit_o && ctl_q[B_CLR]) cnt_d = '0;
    else if (inc_o)               cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
    cnt_en   = cnt_we | inc_o | (hit_o & ctl_q[B_CLR]);
    mat_d    = wdata;
    ctl_d    = wdata[CTLW-1:0] & KEEP;
    if (cnt_we || mat_we)         armed_d = 1'b1;
    else if (hit_o && !ctl_q[B_PER]) armed_d = 1'b0;
    else                          armed_d = armed_q;
    armed_en = cnt_we | mat_we | hit_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mat_q   <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (mat_we)   mat_q   <= mat_d;
      if (ctl_we)   ctl_q   <= ctl_d;
      if (armed_en) armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/ctmr_evt.sv
module ctmr_evt #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           ien_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] ien_q,
  output logic [NCH-1:0] stat_q,
  output logic           irq
);
  logic [NCH-1:0] stat_d;
  logic           stat_en;

  always_comb begin
    stat_d  = stat_q;
    if (clr_we) stat_d = stat_d & ~wbits;
    stat_d  = stat_d | (hit & ien_q);   // a new event outlives a clear
    stat_en = clr_we | (|(hit & ien_q));
    irq     = |stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (ien_we)  ien_q  <= wbits;
      if (stat_en) stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/ctmr_regif.sv
module ctmr_regif
  import ctmr_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CW   = 32,
  parameter int unsigned CTLW = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [NCH-1:0][CW-1:0]   cnt,
  input  logic [NCH-1:0][CW-1:0]   mat,
  input  logic [NCH-1:0][CTLW-1:0] ctl,
  input  logic [NCH-1:0]           stat,
  input  logic [NCH-1:0]           ien,
  output logic [NCH-1:0]           cnt_we,
  output logic [NCH-1:0]           mat_we,
  output logic [NCH-1:0]           ctl_we,
  output logic                     clr_we,
  output logic                     ien_we,
  output logic [CW-1:0]            snap_q,
  output logic [CW-1:0]            rdata,
  output logic                     rvalid
);
  localparam int unsigned HALF = NCH / 2;

  logic [CW-1:0] rd_d;
  logic [CW-1:0] snap_d;
  logic          snap_en;

  // write decode
  always_comb begin
    clr_we = wr_en && (addr == A_STAT);
    ien_we = wr_en && (addr == A_IEN);
    for (int i = 0; i < NCH; i++) begin
      cnt_we[i] = wr_en && (addr == A_CNT + AW'(4 * i));
      mat_we[i] = wr_en && (addr == A_MAT + AW'(4 * i));
      ctl_we[i] = wr_en && (addr == A_CTL + AW'(4 * i));
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (addr == A_STAT) rd_d = {{(CW-NCH){1'b0}}, stat} << FIRST;
    if (addr == A_IEN)  rd_d = {{(CW-NCH){1'b0}}, ien} << FIRST;
    if (addr == A_SNAP) rd_d = snap_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == A_CNT + AW'(4 * i)) rd_d = cnt[i];
      if (addr == A_MAT + AW'(4 * i)) rd_d = mat[i];
      if (addr == A_CTL + AW'(4 * i)) rd_d = {{(CW-CTLW){1'b0}}, ctl[i]};
    end
  end

  // snapshot capture on reads of the upper odd counters
  always_comb begin
    snap_d  = snap_q;
    snap_en = 1'b0;
    for (int i = HALF + 1; i < NCH; i += 2) begin
      if (rd_en && (addr == A_CNT + AW'(4 * i)) && ctl[i][B_SNAP]) begin
        snap_d  = cnt[i-1];
        snap_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)   rdata  <= rd_d;
      if (snap_en) snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/ctmr_bank.sv
module ctmr_bank
  import ctmr_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CW   = 32,
  parameter int unsigned CTLW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    rdata,
  output logic             rvalid,
  input  logic [NTICK-1:0] tick,
  output logic             irq
);
  localparam int unsigned HALF = NCH / 2;

  logic [1:0]                rst_sync_q;
  logic                      rst_core_n;
  logic [NCH-1:0][CW-1:0]    cnt;
  logic [NCH-1:0][CW-1:0]    mat;
  logic [NCH-1:0][CTLW-1:0]  ctl;
  logic [NCH-1:0]            inc;
  logic [NCH-1:0]            hit;
  logic [NCH-1:0]            cnt_we, mat_we, ctl_we;
  logic                      clr_we, ien_we;
  logic [NCH-1:0]            ien_q, stat_q;
  logic [CW-1:0]             snap_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit ODD = (i % 2) == 1;
    localparam int unsigned PI = ODD ? i - 1 : i;
    ctmr_chan #(
      .CW     (CW),
      .CTLW   (CTLW),
      .IS_EXT (i >= HALF),
      .IS_ODD (ODD)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cnt_we   (cnt_we[i]),
      .mat_we   (mat_we[i]),
      .ctl_we   (ctl_we[i]),
      .wdata    (wdata),
      .tick_in  (tick),
      .part_cnt (cnt[PI]),
      .part_inc (inc[PI]),
      .cnt_q    (cnt[i]),
      .inc_o    (inc[i]),
      .hit_o    (hit[i]),
      .mat_q    (mat[i]),
      .ctl_q    (ctl[i])
    );
  end

  ctmr_evt #(.NCH(NCH)) u_evt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .hit    (hit),
    .ien_we (ien_we),
    .clr_we (clr_we),
    .wbits  (wdata[FIRST+NCH-1:FIRST]),
    .ien_q  (ien_q),
    .stat_q (stat_q),
    .irq    (irq)
  );

  ctmr_regif #(.NCH(NCH), .CW(CW), .CTLW(CTLW)) u_regif (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .cnt    (cnt),
    .mat    (mat),
    .ctl    (ctl),
    .stat   (stat_q),
    .ien    (ien_q),
    .cnt_we (cnt_we),
    .mat_we (mat_we),
    .ctl_we (ctl_we),
    .clr_we (clr_we),
    .ien_we (ien_we),
    .snap_q (snap_q),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/ctmr_bank_chk.sv
module ctmr_bank_chk
  import ctmr_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CW   = 32,
  parameter int unsigned CTLW = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [AW-1:0]            addr,
  input logic [CW-1:0]            wdata,
  input logic [NCH-1:0][CW-1:0]   cnt,
  input logic [NCH-1:0][CTLW-1:0] ctl,
  input logic [NCH-1:0]           hit,
  input logic [NCH-1:0]           ien,
  input logic [NCH-1:0]           stat,
  input logic [CW-1:0]            snap,
  input logic                     irq
);
  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0][2:0] == 3'd0) && !(wr_en && addr == A_CNT) |=> $stable(cnt[0]));

  p_cnt_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == A_CNT) |=> cnt[0] == $past(wdata));

  p_shared_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[1][B_OWN] && !ctl[1][B_CLR] && !(wr_en && addr == A_CNT + 8'h04)
    |=> $stable(cnt[1]));

  p_snap_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == A_CNT + 8'h14) && ctl[5][B_SNAP] |=> snap == $past(cnt[4]));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == A_STAT) && wdata[FIRST] && !hit[0] |=> !stat[0]);

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(hit & ien)));
endmodule

bind ctmr_bank ctmr_bank_chk #(.NCH(NCH), .CW(CW), .CTLW(CTLW)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .cnt   (cnt),
  .ctl   (ctl),
  .hit   (hit),
  .ien   (ien_q),
  .stat  (stat_q),
  .snap  (snap_q),
  .irq   (irq)
);

// File: tb/ctmr_bank_test.sv
module ctmr_bank_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid;
  logic [4:0]  tk;
  logic        irq;

  int checks   = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  a;
    string       tag;
  } item_t;
  item_t sb[$];

  ctmr_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .tick(tk), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: read data with no expected item, got %h exp none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          failures++;
          $display("FAIL %s addr %h: got %h exp %h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [4:0] m = 5'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tk = m;
    @(negedge clk);
    wr_en = 1'b0; tk = 5'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.a = a; it.tag = tag;
    @(negedge clk);
    sb.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n, input logic [4:0] m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tk = m;
    end
    @(negedge clk);
    tk = 5'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq: got %b exp %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; tk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk_irq(1'b0, "R12");
    rd(8'h14, 32'h0, "R12 status");
    rd(8'hC0, 32'h0, "R12 control");
    rd(8'h40, 32'h0, "R12 counter");
    rd(8'h20, 32'h0, "R12 snapshot");

    // R1 match readback at channel 7
    wr(8'h8C, 32'h0000_1234);
    rd(8'h8C, 32'h0000_1234, "R1 match ch7");

    // R2 code 4 -> tick[3]; other strobes ignored
    wr(8'hC0, 32'h4);
    wr(8'h40, 32'h0);
    ticks(10, 5'b01000);
    ticks(5, 5'b00001);
    rd(8'h40, 32'd10, "R2 code4 count");
    wr(8'hC8, 32'h6);
    ticks(4, 5'b11111);
    rd(8'h48, 32'd0, "R2 code6 stopped");
    wr(8'hC8, 32'h2);
    ticks(3, 5'b00010);
    ticks(2, 5'b10101);
    rd(8'h48, 32'd3, "R2 code2 count");
    wr(8'hC8, 32'h0);

    // R3 counter write collides with a tick
    wr(8'h40, 32'd100, 5'b01000);
    rd(8'h40, 32'd100, "R3 write wins");

    // R8 narrow control on channel 5
    wr(8'hC4, 32'h3FF);
    rd(8'hC4, 32'h0FF, "R8 narrow control");
    wr(8'hC4, 32'h0);

    // R7 halt bit on channel 10, wide control kept
    wr(8'hD8, 32'h184);
    rd(8'hD8, 32'h184, "R7 wide control");
    wr(8'h58, 32'd7);
    ticks(5, 5'b01000);
    rd(8'h58, 32'd7, "R7 halted counter");

    // R4 / R5 / R10: channel 4 periodic with clear-on-match, enabled
    wr(8'h1C, 32'h50);
    rd(8'h1C, 32'h50, "R1 enable readback");
    wr(8'hC0, 32'h4C);
    wr(8'h80, 32'd5);
    wr(8'h40, 32'd0);
    ticks(4, 5'b01000);
    rd(8'h14, 32'h0, "R10 no event before match");
    chk_irq(1'b0, "R10");
    ticks(1, 5'b01000);
    rd(8'h40, 32'd0, "R4 cleared on match");
    rd(8'h14, 32'h10, "R10 event set");
    chk_irq(1'b1, "R10");
    wr(8'h14, 32'h10);
    rd(8'h14, 32'h0, "R10 status cleared");
    chk_irq(1'b0, "R10 drop");
    ticks(5, 5'b01000);
    rd(8'h14, 32'h10, "R5 periodic second event");
    // R11 clear and match in one cycle
    wr(8'h14, 32'h10);
    ticks(4, 5'b01000);
    wr(8'h14, 32'h10, 5'b01000);
    rd(8'h14, 32'h10, "R11 event beats clear");
    wr(8'hC0, 32'h0);
    wr(8'h14, 32'h10);

    // R5 one-shot on channel 6
    wr(8'hC8, 32'h0C);
    wr(8'h88, 32'd3);
    wr(8'h48, 32'd0);
    ticks(3, 5'b01000);
    rd(8'h14, 32'h40, "R5 one-shot fires");
    wr(8'h14, 32'h40);
    ticks(3, 5'b01000);
    rd(8'h48, 32'd3, "R5 one-shot counter");
    rd(8'h14, 32'h0, "R5 one-shot silent");
    wr(8'hC8, 32'h0);

    // R10 gating: channel 4 matches with enable off
    wr(8'h1C, 32'h40);
    wr(8'hC0, 32'h4C);
    wr(8'h40, 32'd0);
    ticks(5, 5'b01000);
    rd(8'h40, 32'd0, "R10 gated match occurred");
    rd(8'h14, 32'h0, "R10 gated no event");
    wr(8'hC0, 32'h0);

    // R6 sharing: channel 5 compares against channel 4
    wr(8'h1C, 32'h20);
    wr(8'h44, 32'd50);
    wr(8'hC4, 32'h44);
    wr(8'h84, 32'd7);
    wr(8'h40, 32'd0);
    wr(8'hC0, 32'h4);
    ticks(7, 5'b01000);
    rd(8'h14, 32'h20, "R6 shared match");
    rd(8'h44, 32'd50, "R6 own counter held");
    rd(8'h40, 32'd7, "R6 partner counter");
    wr(8'hC0, 32'h0);
    wr(8'h14, 32'h20);
    wr(8'hC4, 32'h84);
    wr(8'h44, 32'd0);
    wr(8'h84, 32'd3);
    ticks(3, 5'b01000);
    rd(8'h14, 32'h20, "R6 own counter match");
    rd(8'h44, 32'd3, "R6 own counter ran");
    rd(8'h40, 32'd7, "R6 partner untouched");

    // R9 snapshot
    wr(8'hD0, 32'h4);
    wr(8'h50, 32'd0);
    ticks(9, 5'b01000);
    wr(8'hD0, 32'h0);
    wr(8'hD4, 32'h200);
    rd(8'h54, 32'd0, "R9 ch9 counter");
    rd(8'h20, 32'd9, "R9 snapshot captured");
    wr(8'h50, 32'd20);
    rd(8'h5C, 32'd0, "R9 ch11 counter");
    rd(8'h20, 32'd9, "R9 snapshot unchanged");
    rd(8'h54, 32'd0, "R9 ch9 counter again");
    rd(8'h20, 32'd20, "R9 snapshot recaptured");

    repeat (5) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
    end
    report();
  end
endmodule